// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 96 level-sensitive interrupt sources, arranged as three banks of 32, and presents them to a processor as one request line together with a vector register. Source n is bit n%32 of bank n/32. A request that is seen on a source is latched into that source's pending bit. A source is reported only when its pending bit is 1, its enable bit is 1 and its mask bit is 0. Software finds the winning source by reading the vector register, services it, and clears its pending bit by writing a one to that bit.

The register side is a plain 32-bit port with an 8-bit byte address, a write strobe, write data and read data. A write takes effect at the clock edge, and read data follows the address within the same cycle. A protection bit can fence the registers off from accesses made without privilege. A trigger-type field decides how one external pin is detected, and that pin drives source 1.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every pending, enable and mask bank reads 0. The protection register (0x08) and the trigger-type register (0x0C) read 0, the vector register (0x00) reads 0, and `irq_req` is low.
- R2: A source input that is high at a clock edge sets its pending bit at that edge. Pending banks read at 0x10, 0x14 and 0x18, one per bank, with source n at bit n%32.
- R3: Writing a pending bank clears every bit written as 1 at that edge, and bits written as 0 keep their value. If the source is still high, the bit is set again at the following edge.
- R4: `irq_req` is high exactly when some source from 1 to 95 has pending=1, enable=1 and mask=0. It follows the register state without an added cycle.
- R5: Enable banks (0x40, 0x44, 0x48) and mask banks (0x50, 0x54, 0x58) hold written values and read them back. A set mask bit or a cleared enable bit stops a pending source from being reported.
- R6: Reading 0x00 returns the lowest-numbered eligible source in bits [8:2], with every other bit 0. It reads 0 when no source is eligible.
- R7: Source 0 is never reported. Its pending bit can be set and read, but it raises neither `irq_req` nor a nonzero vector.
- R8: Bit 0 of 0x08 turns protection on. While it is 1 and `priv` is low, writes to any register are ignored and reads return 0. With `priv` high, access is normal.
- R9: Bits [1:0] of 0x0C select how `ext_in` is detected onto source 1: 00 low level, 01 high level, 10 falling edge, 11 rising edge. The result is ORed with `irq_src[1]`. A qualifying level or edge sets pending bit 1 of bank 0 at the next clock edge.
- R10: In the two edge modes, a pending bit 1 that has been cleared stays clear while `ext_in` holds a steady level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | 96 | Level-sensitive interrupt sources |
| ext_in | input | 1 | External pin, detected onto source 1 |
| priv | input | 1 | Access is privileged |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
Each result has a fixed due time:
- A register write is visible at the clock edge that takes it.
- A source level or an `ext_in` edge reaches its pending bit at the next edge.
- `irq_req` and the vector follow that pending bit with no further delay.
- Read data is combinational from `addr`.

The bench changes its inputs one time unit after a rising edge and steps exactly one edge for each registered stage. Its monitor samples `rdata` and `irq_req` at the following falling edge, well away from any register update. The clear-then-reset-again cases are checked in two steps, the read right after the clearing edge and the read one edge later, so the two due times are told apart.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  localparam int REG_W = 32;

  // register groups decoded from address bits [7:4]
  localparam logic [3:0] GRP_CTRL = 4'h0;
  localparam logic [3:0] GRP_PEND = 4'h1;
  localparam logic [3:0] GRP_EN   = 4'h4;
  localparam logic [3:0] GRP_MASK = 4'h5;

  // word slots inside the control group, address bits [3:2]
  localparam logic [1:0] SLOT_VEC  = 2'd0;
  localparam logic [1:0] SLOT_PROT = 2'd2;
  localparam logic [1:0] SLOT_TRIG = 2'd3;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;

  // detection rule for the external pin
  function automatic logic trig_hit(trig_e mode, logic now, logic prev);
    logic hit;
    case (mode)
      TRIG_LOW:  hit = ~now;
      TRIG_HIGH: hit = now;
      TRIG_FALL: hit = prev & ~now;
      default:   hit = ~prev & now;
    endcase
    return hit;
  endfunction

  // vector word layout: source number shifted up by two
  function automatic logic [REG_W-1:0] vec_word(int unsigned idx);
    return REG_W'(idx) << 2;
  endfunction

endpackage

// File: rtl/ivc_ext_detect.sv
module ivc_ext_detect
  import ivc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ext_in,
  input  trig_e mode,
  output logic  hit
);

  logic ext_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_in;
  end

  assign hit = trig_hit(mode, ext_in, ext_q);

  // an edge mode fires for a single cycle per transition
  p_edge_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && hit) |=> (!hit || !$stable(mode)))
    else $error("edge detector fired twice");

endmodule

// File: rtl/ivc_bank.sv
module ivc_bank #(
  parameter int W         = 32,
  parameter bit DROP_BIT0 = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req,
  input  logic         wr_pend,
  input  logic         wr_en,
  input  logic         wr_mask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend,
  output logic [W-1:0] en,
  output logic [W-1:0] msk,
  output logic [W-1:0] elig
);

  localparam logic [W-1:0] KEEP = DROP_BIT0 ? ~W'(1) : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      en   <= '0;
      msk  <= '0;
    end else begin
      if (wr_pend) pend <= pend & ~wdata;
      else         pend <= pend | req;
      if (wr_en)   en   <= wdata;
      if (wr_mask) msk  <= wdata;
    end
  end

  assign elig = pend & en & ~msk & KEEP;

  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> ((pend & $past(wdata)) == '0))
    else $error("pending bit survived a clear");

  p_level_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pend |=> ((pend & $past(req)) == $past(req)))
    else $error("active source not latched");

  p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en))
    else $error("enable changed without a write");

endmodule

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
  parameter int N  = 96,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  elig,
  output logic [IW-1:0] idx
);

  // lowest set bit from 1 upward; bit 0 is never a candidate
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 1; i--) begin
      if (elig[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  localparam int BANK_W   = REG_W,
  localparam int NUM_SRC  = NUM_BANKS * BANK_W,
  localparam int IDX_W    = $clog2(NUM_SRC),
  localparam int ADDR_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               ext_in,
  input  logic               priv,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  output logic               irq_req
);

  // bank index lives in addr[3:2], so at most four banks fit the map
  logic [3:0] grp;
  logic [1:0] slot;
  logic       aligned;
  logic       blocked;
  logic       wr_ok;

  assign grp     = addr[7:4];
  assign slot    = addr[3:2];
  assign aligned = (addr[1:0] == 2'b00);

  logic  prot_q;
  trig_e mode_q;

  assign blocked = prot_q & ~priv;
  assign wr_ok   = wr_en & ~blocked & aligned;

  // external pin onto source 1
  logic ext_hit;
  ivc_ext_detect u_ext (
    .clk   (clk),
    .rst_n (rst_n),
    .ext_in(ext_in),
    .mode  (mode_q),
    .hit   (ext_hit)
  );

  logic [NUM_SRC-1:0] src_eff;
  assign src_eff = irq_src | (NUM_SRC'(ext_hit) << 1);

  logic [NUM_BANKS-1:0][BANK_W-1:0] req_b, pend_b, en_b, msk_b, elig_b;
  logic [NUM_BANKS-1:0] wp, we, wm;
  assign req_b = src_eff;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign wp[b] = wr_ok & (grp == GRP_PEND) & (slot == 2'(b));
    assign we[b] = wr_ok & (grp == GRP_EN)   & (slot == 2'(b));
    assign wm[b] = wr_ok & (grp == GRP_MASK) & (slot == 2'(b));

    ivc_bank #(
      .W        (BANK_W),
      .DROP_BIT0(b == 0)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req_b[b]),
      .wr_pend(wp[b]),
      .wr_en  (we[b]),
      .wr_mask(wm[b]),
      .wdata  (wdata),
      .pend   (pend_b[b]),
      .en     (en_b[b]),
      .msk    (msk_b[b]),
      .elig   (elig_b[b])
    );
  end

  logic [NUM_SRC-1:0] elig_flat;
  logic [IDX_W-1:0]   vec_idx;
  assign elig_flat = elig_b;
  assign irq_req   = |elig_flat;

  ivc_prio_enc #(.N(NUM_SRC), .IW(IDX_W)) u_prio (
    .elig(elig_flat),
    .idx (vec_idx)
  );

  // control registers
  logic wr_ctrl;
  assign wr_ctrl = wr_ok & (grp == GRP_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
      mode_q <= TRIG_LOW;
    end else if (wr_ctrl) begin
      if (slot == SLOT_PROT) prot_q <= wdata[0];
      if (slot == SLOT_TRIG) mode_q <= trig_e'(wdata[1:0]);
    end
  end

  // read mux
  logic [REG_W-1:0] rd_raw;
  always_comb begin
    rd_raw = '0;
    if (aligned) begin
      case (grp)
        GRP_CTRL: begin
          case (slot)
            SLOT_VEC:  rd_raw = vec_word(32'(vec_idx));
            SLOT_PROT: rd_raw = {{(REG_W-1){1'b0}}, prot_q};
            SLOT_TRIG: rd_raw = {{(REG_W-2){1'b0}}, mode_q};
            default:   rd_raw = '0;
          endcase
        end
        GRP_PEND: for (int b = 0; b < NUM_BANKS; b++) if (slot == 2'(b)) rd_raw = pend_b[b];
        GRP_EN:   for (int b = 0; b < NUM_BANKS; b++) if (slot == 2'(b)) rd_raw = en_b[b];
        GRP_MASK: for (int b = 0; b < NUM_BANKS; b++) if (slot == 2'(b)) rd_raw = msk_b[b];
        default:  rd_raw = '0;
      endcase
    end
  end

  assign rdata = blocked ? '0 : rd_raw;

  p_req_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (vec_idx != '0))
    else $error("request line disagrees with encoder");

  p_vec_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> elig_flat[vec_idx])
    else $error("vector names an ineligible source");

  p_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q && !priv && wr_en) |=> ($stable(prot_q) && $stable(mode_q)))
    else $error("unprivileged write landed");

endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;

  localparam int NS = 96;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] irq_src;
  logic          ext_in;
  logic          priv;
  logic [7:0]    addr;
  logic          wr_en;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic          irq_req;

  always #5 clk = ~clk;

  irq_vector_ctrl dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_src(irq_src),
    .ext_in (ext_in),
    .priv   (priv),
    .addr   (addr),
    .wr_en  (wr_en),
    .wdata  (wdata),
    .rdata  (rdata),
    .irq_req(irq_req)
  );

  typedef struct packed {
    logic        is_irq;
    logic [31:0] exp;
    logic [7:0]  rq;
  } item_t;

  item_t       sbq[$];
  item_t       mit;
  logic [31:0] got;
  int          n_run  = 0;
  int          n_fail = 0;
  logic        mon_go = 1'b0;
  logic        done   = 1'b0;

  // monitor: pops one expectation per marked cycle, samples at the falling edge
  always @(negedge clk) begin
    if (mon_go && sbq.size() > 0) begin
      mit = sbq.pop_front();
      got = mit.is_irq ? {31'b0, irq_req} : rdata;
      n_run++;
      if (got !== mit.exp) begin
        n_fail++;
        $display("FAIL R%0d: got 0x%08h expected 0x%08h", mit.rq, got, mit.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr  = a;
    wdata = d;
    wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input logic [7:0] rq);
    addr = a;
    sbq.push_back('{1'b0, e, rq});
    mon_go = 1'b1;
    @(negedge clk);
    #1;
    mon_go = 1'b0;
  endtask

  task automatic expect_irq(input logic e, input logic [7:0] rq);
    sbq.push_back('{1'b1, {31'b0, e}, rq});
    mon_go = 1'b1;
    @(negedge clk);
    #1;
    mon_go = 1'b0;
  endtask

  // vector word restated: source number times four
  function automatic logic [31:0] vword(int n);
    return 32'(n * 4);
  endfunction

  initial begin
    rst_n = 1'b0; irq_src = '0; ext_in = 1'b1; priv = 1'b1;
    addr = '0; wr_en = 1'b0; wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    expect_rd(8'h10, 0, 1); expect_rd(8'h14, 0, 1); expect_rd(8'h18, 0, 1);
    expect_rd(8'h40, 0, 1); expect_rd(8'h54, 0, 1);
    expect_rd(8'h08, 0, 1); expect_rd(8'h0C, 0, 1); expect_rd(8'h00, 0, 1);
    expect_irq(1'b0, 1);

    // R2 latch source 37 into bank 1 bit 5; R4 not enabled yet
    irq_src[37] = 1'b1; tick();
    expect_rd(8'h14, 32'h20, 2);
    expect_irq(1'b0, 4);

    // R5 enable readback, R4 request, R6 vector
    wr(8'h44, 32'h20);
    expect_rd(8'h44, 32'h20, 5);
    expect_irq(1'b1, 4);
    expect_rd(8'h00, vword(37), 6);

    // R5 mask hides the source
    wr(8'h54, 32'h20);
    expect_irq(1'b0, 5);
    expect_rd(8'h00, 0, 6);
    expect_rd(8'h54, 32'h20, 5);
    wr(8'h54, 32'h0);

    // R6 lowest-numbered eligible source wins
    irq_src[70] = 1'b1;
    wr(8'h48, 32'h40);
    expect_rd(8'h18, 32'h40, 2);
    expect_rd(8'h00, vword(37), 6);
    irq_src[3] = 1'b1;
    wr(8'h40, 32'h8);
    expect_rd(8'h00, vword(3), 6);

    // R3 clear while the source is still high, then it comes back
    wr(8'h10, 32'h8);
    expect_rd(8'h10, 0, 3);
    tick();
    expect_rd(8'h10, 32'h8, 3);
    irq_src[3] = 1'b0;
    wr(8'h10, 32'h8);
    tick();
    expect_rd(8'h10, 0, 3);
    expect_rd(8'h00, vword(37), 6);
    irq_src[37] = 1'b0;
    wr(8'h14, 32'h0);
    expect_rd(8'h14, 32'h20, 3);

    // R7 source 0 latches but is never reported
    irq_src[0] = 1'b1;
    wr(8'h40, 32'h9);
    tick();
    expect_rd(8'h10, 32'h1, 7);
    irq_src[70] = 1'b0;
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    expect_rd(8'h00, 0, 7);
    expect_irq(1'b0, 7);
    irq_src[0] = 1'b0;
    wr(8'h10, 32'hFFFF_FFFF);
    expect_rd(8'h10, 0, 3);

    // R9 low-level mode on source 1
    wr(8'h40, 32'h2);
    ext_in = 1'b0; tick();
    expect_rd(8'h10, 32'h2, 9);
    expect_rd(8'h00, vword(1), 9);
    ext_in = 1'b1;
    wr(8'h10, 32'hFFFF_FFFF);
    tick();
    expect_rd(8'h10, 0, 9);

    // R9 high-level mode
    wr(8'h0C, 32'h1);
    expect_rd(8'h0C, 32'h1, 9);
    tick();
    expect_rd(8'h10, 32'h2, 9);

    // R9 rising edge, R10 stays clear afterwards
    ext_in = 1'b0;
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h3);
    tick();
    expect_rd(8'h10, 0, 9);
    ext_in = 1'b1; tick();
    expect_rd(8'h10, 32'h2, 9);
    wr(8'h10, 32'hFFFF_FFFF);
    tick(); tick();
    expect_rd(8'h10, 0, 10);
    expect_irq(1'b0, 10);

    // R9 falling edge, R10 stays clear afterwards
    wr(8'h0C, 32'h2);
    ext_in = 1'b0; tick();
    expect_rd(8'h10, 32'h2, 9);
    wr(8'h10, 32'hFFFF_FFFF);
    tick();
    expect_rd(8'h10, 0, 10);

    // R8 protection
    wr(8'h08, 32'h1);
    expect_rd(8'h08, 32'h1, 8);
    priv = 1'b0;
    expect_rd(8'h08, 0, 8);
    wr(8'h44, 32'hFFFF);
    wr(8'h08, 32'h0);
    irq_src[37] = 1'b1; tick();
    irq_src[37] = 1'b0;
    wr(8'h14, 32'hFFFF_FFFF);
    priv = 1'b1;
    expect_rd(8'h44, 32'h20, 8);
    expect_rd(8'h08, 32'h1, 8);
    expect_rd(8'h14, 32'h20, 8);
    expect_irq(1'b1, 8);
    expect_rd(8'h00, vword(37), 8);
    wr(8'h08, 32'h0);
    expect_rd(8'h08, 0, 8);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule